// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a soft model of a small programmable logic array: four logic inputs, six product terms and three outputs. Each product term is the AND of any chosen subset of input literals, where every input offers both its true and its complemented form. Each output is the OR of any chosen subset of the product terms. Because both planes are programmable, one product term can feed several outputs at once. Six terms are far fewer than the sixteen possible minterms, so the array suits functions that reduce to a few shared terms.

The configuration lives in internal registers and is loaded through a word-addressed write port. Words 0 to 5 hold the literal-selection mask of terms 0 to 5. Words 6 to 11 hold the output-connection mask of terms 0 to 5. Words 12 to 15 are unused. Once loaded, the inputs reach the outputs through combinational logic only, with no clock in the path.

Top module: `pla_array`

## Requirements
- R1: While the block is in reset, and after reset until the first configuration write, every literal mask and connection mask is clear and `out_vec` is 0 for every input value.
- R2: A literal mask word uses bit 2i for the true form of input i and bit 2i+1 for its complement. A term is 1 exactly when every selected literal is 1.
- R3: A term whose literal mask is all zero evaluates to 1.
- R4: A term that selects both the true and the complement of the same input evaluates to 0 for every input value.
- R5: Output j is the OR of the terms whose connection mask has bit j set. An output with no connected term is 0.
- R6: One term connected to several outputs drives all of them at the same time.
- R7: A write with `cfg_we` high at address a loads `cfg_wdata` (bits 7:0 for a literal mask at a = 0..5; bits 2:0 for a connection mask at a = 6..11, term a-6) on the next rising clock edge. Before that edge the outputs still reflect the old configuration. With `cfg_we` low, the configuration does not change.
- R8: A write to addresses 12 to 15 leaves the whole configuration unchanged.
- R9: Once configured, `out_vec` follows a change on `in_vec` combinationally, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 8 | Configuration write data |
| in_vec | input | 4 | Logic inputs |
| out_vec | output | 3 | Sum-of-products outputs |

## Verification
The hardest case to reach from the ports is a term whose literal selection contradicts itself. Nothing shows such a term unless it is also connected to an output and no other term already drives that output high. The stimulus therefore loads contradictory masks on terms that are the only driver of an output and sweeps all sixteen input values. Random configurations are then loaded, each followed by a full input sweep, so that shared terms, empty terms and unconnected outputs all occur and are compared against a model of the configuration kept in the bench.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LIT  = 2'd1,
    SEL_CONN = 2'd2
  } pla_sel_e;

  // column index of an input literal inside a literal mask word
  function automatic int lit_col(input int idx, input bit inverted);
    return 2 * idx + (inverted ? 1 : 0);
  endfunction

endpackage

// File: rtl/pla_rst_sync.sv
`timescale 1ns/1ps
module pla_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pla_cfg_regs.sv
`timescale 1ns/1ps
module pla_cfg_regs
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [N_TERM-1:0][LIT_W-1:0]      lit_mask_q,
  output logic [N_TERM-1:0][N_OUT-1:0]      conn_mask_q
);

  pla_sel_e          sel;
  int                row;
  logic [N_TERM-1:0] lit_en;
  logic [N_TERM-1:0] conn_en;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    row = 0;
    if (int'(cfg_addr) < N_TERM) begin
      sel = SEL_LIT;
      row = int'(cfg_addr);
    end else if (int'(cfg_addr) < 2 * N_TERM) begin
      sel = SEL_CONN;
      row = int'(cfg_addr) - N_TERM;
    end
  end

  // per-row clock enables
  always_comb begin
    lit_en  = '0;
    conn_en = '0;
    for (int t = 0; t < N_TERM; t++) begin
      lit_en[t]  = cfg_we && (sel == SEL_LIT)  && (row == t);
      conn_en[t] = cfg_we && (sel == SEL_CONN) && (row == t);
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    logic [LIT_W-1:0] lit_d;
    logic [N_OUT-1:0] conn_d;

    always_comb begin
      lit_d  = cfg_wdata[LIT_W-1:0];
      conn_d = cfg_wdata[N_OUT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lit_mask_q[t] <= '0;
      end else if (lit_en[t]) begin
        lit_mask_q[t] <= lit_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        conn_mask_q[t] <= '0;
      end else if (conn_en[t]) begin
        conn_mask_q[t] <= conn_d;
      end
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]              in_vec,
  input  logic [N_TERM-1:0][LIT_W-1:0] lit_mask,
  output logic [N_TERM-1:0]            term_val
);

  logic [LIT_W-1:0] literals;

  // true and complement columns for every input
  always_comb begin
    literals = '0;
    for (int i = 0; i < N_IN; i++) begin
      literals[lit_col(i, 1'b0)] = in_vec[i];
      literals[lit_col(i, 1'b1)] = ~in_vec[i];
    end
  end

  // a term is 1 when no selected literal is 0
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    always_comb begin
      term_val[t] = &(literals | ~lit_mask[t]);
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6
) (
  input  logic [N_TERM-1:0]            term_val,
  input  logic [N_TERM-1:0][N_OUT-1:0] conn_mask,
  output logic [N_OUT-1:0]             out_vec
);

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] column;

    always_comb begin
      for (int t = 0; t < N_TERM; t++) begin
        column[t] = conn_mask[t][j];
      end
      out_vec[j] = |(term_val & column);
    end
  end

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array #(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 3,
  parameter int N_TERM  = 6,
  localparam int LIT_W  = 2 * N_IN,
  localparam int DATA_W = (LIT_W > N_OUT) ? LIT_W : N_OUT,
  localparam int ADDR_W = $clog2(2 * N_TERM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);

  logic                         core_rst_n;
  logic [N_TERM-1:0][LIT_W-1:0] and_mask_q;
  logic [N_TERM-1:0][N_OUT-1:0] or_mask_q;
  logic [N_TERM-1:0]            term_val;

  pla_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  pla_cfg_regs #(
    .N_IN   (N_IN),
    .N_OUT  (N_OUT),
    .N_TERM (N_TERM),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cfg_regs (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .lit_mask_q  (and_mask_q),
    .conn_mask_q (or_mask_q)
  );

  pla_and_plane #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM)
  ) u_and_plane (
    .in_vec   (in_vec),
    .lit_mask (and_mask_q),
    .term_val (term_val)
  );

  pla_or_plane #(
    .N_OUT  (N_OUT),
    .N_TERM (N_TERM)
  ) u_or_plane (
    .term_val  (term_val),
    .conn_mask (or_mask_q),
    .out_vec   (out_vec)
  );

endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int N_TERM = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int LIT_W = 2 * N_IN
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         core_rst_n,
  input logic                         cfg_we,
  input logic [ADDR_W-1:0]            cfg_addr,
  input logic [DATA_W-1:0]            cfg_wdata,
  input logic [N_OUT-1:0]             out_vec,
  input logic [N_TERM-1:0][LIT_W-1:0] and_mask,
  input logic [N_TERM-1:0][N_OUT-1:0] or_mask,
  input logic [N_TERM-1:0]            term_val
);

  logic              bad_addr;
  logic [N_TERM-1:0] conflict;
  logic [N_OUT-1:0]  no_driver;

  always_comb begin
    bad_addr = int'(cfg_addr) >= 2 * N_TERM;
    conflict = '0;
    for (int t = 0; t < N_TERM; t++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (and_mask[t][2*i] && and_mask[t][2*i+1]) conflict[t] = 1'b1;
      end
    end
    no_driver = '1;
    for (int j = 0; j < N_OUT; j++) begin
      for (int t = 0; t < N_TERM; t++) begin
        if (or_mask[t][j]) no_driver[j] = 1'b0;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (out_vec == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && !cfg_we) |=> ($stable(and_mask) && $stable(or_mask))); // R7

  AST_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && bad_addr) |=> ($stable(and_mask) && $stable(or_mask))); // R8

  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    AST_LIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_n && cfg_we && int'(cfg_addr) == t)
        |=> (and_mask[t] == $past(cfg_wdata[LIT_W-1:0]))); // R7

    AST_CONN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_n && cfg_we && int'(cfg_addr) == t + N_TERM)
        |=> (or_mask[t] == $past(cfg_wdata[N_OUT-1:0]))); // R7

    AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (and_mask[t] == '0) |-> term_val[t]); // R3

    AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      conflict[t] |-> !term_val[t]); // R4
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
    AST_NO_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      no_driver[j] |-> !out_vec[j]); // R5
  end

endmodule

bind pla_array pla_array_chk #(
  .N_IN   (N_IN),
  .N_OUT  (N_OUT),
  .N_TERM (N_TERM),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .out_vec    (out_vec),
  .and_mask   (and_mask_q),
  .or_mask    (or_mask_q),
  .term_val   (term_val)
);

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb;

  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NT = 6;

  typedef struct {
    logic [NO-1:0] exp;
    logic [NI-1:0] stim;
    string         tag;
  } sb_item_t;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [7:0]    cfg_wdata;
  logic [NI-1:0] in_vec;
  logic [NO-1:0] out_vec;

  int errors;
  int checks;
  bit done;

  sb_item_t  sbq[$];
  logic [7:0] m_and [NT];
  logic [2:0] m_or  [NT];

  pla_array u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_vec    (in_vec),
    .out_vec   (out_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bench model of the configured array
  function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    r = '0;
    for (int t = 0; t < NT; t++) begin
      bit on;
      on = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (m_and[t][2*i]   && !x[i]) on = 1'b0;
        if (m_and[t][2*i+1] &&  x[i]) on = 1'b0;
      end
      if (on) r = r | m_or[t];
    end
    return r;
  endfunction

  task automatic check(input logic [NO-1:0] act, input logic [NO-1:0] exp,
                       input string tag, input logic [NI-1:0] x);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%b: actual=%b expected=%b", tag, x, act, exp);
    end
  endtask

  // driver: apply one input value and push its expected result
  task automatic drive(input logic [NI-1:0] x, input string tag);
    sb_item_t it;
    @(negedge clk);
    in_vec = x;
    it.exp  = model(x);
    it.stim = x;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 16; v++) drive(NI'(v), tag);
  endtask

  // configuration write; old config before the edge, new after (R7)
  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    #1;
    check(out_vec, model(in_vec), "R7 before edge", in_vec);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (a < 4'(NT))          m_and[a] = d;
    else if (a < 4'(2 * NT)) m_or[a - 4'(NT)] = d[2:0];
    check(out_vec, model(in_vec), "R7 after edge", in_vec);
  endtask

  // monitor: pop and compare once per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        check(out_vec, it.exp, it.tag, it.stim);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    errors = 0;
    checks = 0;
    done   = 1'b0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    in_vec    = '0;
    for (int t = 0; t < NT; t++) begin
      m_and[t] = '0;
      m_or[t]  = '0;
    end
    void'($urandom(32'h5a17));

    repeat (3) @(posedge clk);
    #1;
    check(out_vec, 3'b000, "R1 in reset", in_vec);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: cleared configuration gives all zeros
    sweep("R1 after reset");

    // R3 + R5: empty term 0 on output 0 only
    cfg_write(4'd6, 8'h01);
    sweep("R3 empty term / R5 unconnected outputs");

    // R2: term 1 = in0 & ~in2 (bits 0 and 5) on output 1
    cfg_write(4'd0, 8'h03);          // term 0 now in0 & ~in0: R4 conflict
    cfg_write(4'd1, 8'h21);
    cfg_write(4'd7, 8'h02);
    sweep("R2 literal select / R4 conflict on out0");

    // R6: term 1 shared by outputs 1 and 2
    cfg_write(4'd7, 8'h06);
    sweep("R6 shared term");

    // R4: conflicting term 2 (in1 both forms) as sole extra driver
    cfg_write(4'd2, 8'h0C);
    cfg_write(4'd7, 8'h02);
    cfg_write(4'd8, 8'h04);
    sweep("R4 conflict term");

    // R8: writes to unused addresses change nothing
    for (int a = 12; a < 16; a++) cfg_write(4'(a), 8'hFF);
    sweep("R8 unused address");

    // R9: output follows input with no clock edge in between
    cfg_write(4'd3, 8'h40);          // term 3 = in3
    cfg_write(4'd9, 8'h01);
    @(negedge clk);
    in_vec = 4'h8;
    #1 check(out_vec, model(in_vec), "R9 comb rise", in_vec);
    in_vec = 4'h0;
    #1 check(out_vec, model(in_vec), "R9 comb fall", in_vec);
    in_vec = 4'h9;
    #1 check(out_vec, model(in_vec), "R9 comb change", in_vec);

    // random configurations: R2 R3 R4 R5 R6 together
    for (int k = 0; k < 12; k++) begin
      for (int t = 0; t < NT; t++) begin
        logic [7:0] r;
        r = 8'($urandom);
        if (k % 4 == 0) r = r & 8'h55;  // true-only literals
        cfg_write(4'(t), r);
        cfg_write(4'(t + NT), 8'($urandom));
      end
      sweep("R5 random sum of products");
    end

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule